// File: doc/BRIEF.md
# Round-Robin Arbiter Multiplexer with Selectable Grant Retention

This block merges several ready/valid streams into one. Every input offers a word with its `in_srdy` bit and takes the word away when its `in_drdy` bit is high in the same cycle. A round-robin arbiter grants one input at a time. The granted input's data is loaded into a registered output stage, and the stage offers the word downstream on `o_srdy`/`o_data` until `o_drdy` takes it.

The arbiter is deliberately slow. It decides from registered state, and a new grant takes effect one cycle after it is chosen. Once a grant is released, one cycle passes with no input granted before the next choice. The `grant_mode` input chooses how long a grant lasts:

- Mode 0: the grant lasts one word.
- Mode 1: the grant lasts a burst, which runs while the granted input keeps its valid high.
- Mode 2: the grant lasts a whole packet, which ends on a word that matches a masked end pattern. A gap in valid inside the packet does not end it.

`grant_mode` is meant to be changed only while the block is in reset.

Top module: `rr_mux_arb`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `o_srdy` is low and every `in_drdy` bit is low.
- R2: When no grant is held and at least one `in_srdy` bit is high, the grant goes to the first requesting input found when searching upward (with wraparound) from the round-robin pointer. The pointer is zero after reset. On each release it moves to the index after the released input. Cycles with no requests leave it unchanged.
- R3: With `grant_mode` equal to 0 or 3, the grant is released after exactly one word is accepted from the granted input.
- R4: With `grant_mode` equal to 1, the grant is kept while the granted input holds `in_srdy` high, whether or not words move. It is released in a cycle where that input's `in_srdy` is low.
- R5: With `grant_mode` equal to 2, the grant is kept until a word satisfying R9 is accepted from the granted input. This holds even through cycles in which that input's `in_srdy` is low.
- R6: A grant is chosen in one cycle and becomes visible on `in_drdy` the next cycle. At most one `in_drdy` bit is high, and only the granted input's bit can be high.
- R7: The granted input's `in_drdy` is high exactly when the output stage is empty or `o_drdy` is high.
- R8: A word accepted from an input appears on `o_data` with `o_srdy` high in the next cycle. It stays there unchanged until a cycle with `o_drdy` high. `o_srdy` falls after that cycle if no new word was accepted.
- R9: A word ends a packet when `(word & END_MASK) == (END_VAL & END_MASK)`. By default this means bit 7 of the word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_mode | input | 2 | Grant retention: 0 per word, 1 burst, 2 packet, 3 as 0 |
| in_srdy | input | N_IN | Per-input valid |
| in_data | input | N_IN*DW | Input words, input i at bits [i*DW +: DW] |
| in_drdy | output | N_IN | Per-input ready, only the granted one can be high |
| o_srdy | output | 1 | Output word valid |
| o_data | output | DW | Output word |
| o_drdy | input | 1 | Downstream ready |

## Verification
The `in_drdy` vector is due in the same cycle as the inputs that drive it. It depends only on registered grant state and on `o_drdy`. The bench therefore drives its inputs at the falling edge and compares `in_drdy` one time step later, against a bench-side cycle model. A word accepted at one rising edge is due on `o_srdy`/`o_data` after that edge, so the bench compares those outputs at the next falling edge. Grant changes are due one edge after the cycle that causes them. The bench checks them through the `in_drdy` comparison of the following cycle, which covers both the one-cycle gap after a release and the round-robin order.

// File: rtl/rr_mux_pkg.sv
package rr_mux_pkg;

  typedef enum logic [1:0] {
    HOLD_WORD   = 2'd0,
    HOLD_BURST  = 2'd1,
    HOLD_PACKET = 2'd2,
    HOLD_ALT    = 2'd3
  } hold_mode_e;

  function automatic hold_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd1:    return HOLD_BURST;
      2'd2:    return HOLD_PACKET;
      default: return HOLD_WORD;
    endcase
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_IN = 4,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0] req,
  input  logic [IW-1:0]   start,
  output logic            found,
  output logic [IW-1:0]   pick
);

  always_comb begin
    int pos;
    found = 1'b0;
    pick  = start;
    // Scan from farthest to nearest so the nearest requester wins.
    for (int k = N_IN - 1; k >= 0; k--) begin
      pos = (int'(start) + k) % N_IN;
      if (req[pos]) begin
        found = 1'b1;
        pick  = IW'(pos);
      end
    end
  end

endmodule

// File: rtl/rr_grant_ctl.sv
module rr_grant_ctl
  import rr_mux_pkg::*;
#(
  parameter int          N_IN     = 4,
  parameter int          DW       = 8,
  parameter logic [DW-1:0] END_VAL  = 8'h80,
  parameter logic [DW-1:0] END_MASK = 8'h80,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  hold_mode_e      mode,
  input  logic            cur_srdy,
  input  logic            xfer,
  input  logic [DW-1:0]   xfer_data,
  input  logic            pick_found,
  input  logic [IW-1:0]   pick_idx,
  output logic            grant_vld,
  output logic [IW-1:0]   grant_idx,
  output logic [IW-1:0]   rr_ptr
);

  logic is_end;
  logic release_now;
  logic [IW-1:0] after_idx;

  assign is_end = ((xfer_data & END_MASK) == (END_VAL & END_MASK));
  assign after_idx = (int'(grant_idx) == N_IN - 1) ? '0 : grant_idx + 1'b1;

  always_comb begin
    case (mode)
      HOLD_BURST:  release_now = !cur_srdy;
      HOLD_PACKET: release_now = xfer && is_end;
      default:     release_now = xfer;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld <= 1'b0;
      grant_idx <= '0;
      rr_ptr    <= '0;
    end else if (!grant_vld) begin
      if (pick_found) begin
        grant_vld <= 1'b1;
        grant_idx <= pick_idx;
      end
    end else if (release_now) begin
      grant_vld <= 1'b0;
      rr_ptr    <= after_idx;
    end
  end

endmodule

// File: rtl/rr_out_reg.sv
module rr_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          o_drdy,
  output logic          o_srdy,
  output logic [DW-1:0] o_data,
  output logic          space
);

  assign space = !o_srdy || o_drdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_srdy <= 1'b0;
      o_data <= '0;
    end else if (load) begin
      o_srdy <= 1'b1;
      o_data <= load_data;
    end else if (o_drdy) begin
      o_srdy <= 1'b0;
    end
  end

endmodule

// File: rtl/rr_mux_arb.sv
module rr_mux_arb
  import rr_mux_pkg::*;
#(
  parameter int            N_IN     = 4,
  parameter int            DW       = 8,
  parameter logic [DW-1:0] END_VAL  = 8'h80,
  parameter logic [DW-1:0] END_MASK = 8'h80,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         grant_mode,
  input  logic [N_IN-1:0]    in_srdy,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [N_IN-1:0]    in_drdy,
  output logic               o_srdy,
  output logic [DW-1:0]      o_data,
  input  logic               o_drdy
);

  logic          grant_vld;
  logic [IW-1:0] grant_idx;
  logic [IW-1:0] rr_ptr;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic          space;
  logic          xfer;
  logic [DW-1:0] sel_data;
  logic          cur_srdy;
  hold_mode_e    mode;

  assign mode     = decode_mode(grant_mode);
  assign cur_srdy = in_srdy[grant_idx];
  assign sel_data = in_data[grant_idx*DW +: DW];
  assign xfer     = grant_vld && cur_srdy && space;

  rr_pick #(.N_IN(N_IN)) u_pick (
    .req   (in_srdy),
    .start (rr_ptr),
    .found (pick_found),
    .pick  (pick_idx)
  );

  rr_grant_ctl #(
    .N_IN(N_IN), .DW(DW), .END_VAL(END_VAL), .END_MASK(END_MASK)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .cur_srdy   (cur_srdy),
    .xfer       (xfer),
    .xfer_data  (sel_data),
    .pick_found (pick_found),
    .pick_idx   (pick_idx),
    .grant_vld  (grant_vld),
    .grant_idx  (grant_idx),
    .rr_ptr     (rr_ptr)
  );

  rr_out_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (xfer),
    .load_data (sel_data),
    .o_drdy    (o_drdy),
    .o_srdy    (o_srdy),
    .o_data    (o_data),
    .space     (space)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_drdy
    assign in_drdy[i] = grant_vld && (int'(grant_idx) == i) && space;
  end

endmodule

// File: rtl/rr_mux_arb_chk.sv
module rr_mux_arb_chk #(
  parameter int            N_IN     = 4,
  parameter int            DW       = 8,
  parameter logic [DW-1:0] END_VAL  = 8'h80,
  parameter logic [DW-1:0] END_MASK = 8'h80,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         grant_mode,
  input logic [N_IN-1:0]    in_srdy,
  input logic [N_IN*DW-1:0] in_data,
  input logic [N_IN-1:0]    in_drdy,
  input logic               o_srdy,
  input logic [DW-1:0]      o_data,
  input logic               o_drdy,
  input logic               grant_vld,
  input logic [IW-1:0]      grant_idx
);

  logic          moved;
  logic [DW-1:0] g_word;
  logic          g_end;

  assign moved  = |(in_srdy & in_drdy);
  assign g_word = in_data[grant_idx*DW +: DW];
  assign g_end  = ((g_word & END_MASK) == (END_VAL & END_MASK));

  assert_one_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_drdy));

  assert_no_grant_no_ready_R6: assert property (@(posedge clk) disable iff (rst)
    !grant_vld |-> (in_drdy == '0));

  assert_ready_follows_space_R7: assert property (@(posedge clk) disable iff (rst)
    (|in_drdy) |-> (!o_srdy || o_drdy));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (o_srdy && !o_drdy) |=> (o_srdy && $stable(o_data)));

  assert_word_release_R3: assert property (@(posedge clk) disable iff (rst)
    ((grant_mode == 2'd0 || grant_mode == 2'd3) && moved) |=> !grant_vld);

  assert_burst_release_R4: assert property (@(posedge clk) disable iff (rst)
    (grant_mode == 2'd1 && grant_vld && !in_srdy[grant_idx]) |=> !grant_vld);

  assert_packet_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (grant_mode == 2'd2 && grant_vld && !(moved && g_end))
      |=> (grant_vld && $stable(grant_idx)));

endmodule

bind rr_mux_arb rr_mux_arb_chk #(
  .N_IN(N_IN), .DW(DW), .END_VAL(END_VAL), .END_MASK(END_MASK)
) u_chk (.*);

// File: tb/tb_rr_mux_arb.sv
module tb_rr_mux_arb;

  localparam int N = 4;
  localparam int DW = 8;
  localparam logic [DW-1:0] EV = 8'h80;
  localparam logic [DW-1:0] EM = 8'h80;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       grant_mode = 2'd0;
  logic [N-1:0]     in_srdy = '0;
  logic [N*DW-1:0]  in_data = '0;
  logic [N-1:0]     in_drdy;
  logic             o_srdy;
  logic [DW-1:0]    o_data;
  logic             o_drdy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit m_gv, m_of;
  int m_gi, m_ptr;
  logic [DW-1:0] m_od;

  always #5 clk = ~clk;

  rr_mux_arb #(.N_IN(N), .DW(DW), .END_VAL(EV), .END_MASK(EM)) dut (
    .clk(clk), .rst(rst), .grant_mode(grant_mode),
    .in_srdy(in_srdy), .in_data(in_data), .in_drdy(in_drdy),
    .o_srdy(o_srdy), .o_data(o_data), .o_drdy(o_drdy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_drdy(input bit dr);
    logic [N-1:0] v = '0;
    if (m_gv && (!m_of || dr)) v[m_gi] = 1'b1;
    return v;
  endfunction

  function automatic bool_end(input logic [DW-1:0] w);
    return ((w & EM) == (EV & EM));
  endfunction

  function automatic int rr_choose(input logic [N-1:0] req, input int start);
    for (int k = 0; k < N; k++) begin
      if (req[(start + k) % N]) return (start + k) % N;
    end
    return -1;
  endfunction

  task automatic model_step();
    bit acc, rel;
    logic [DW-1:0] w;
    int p;
    w   = in_data[m_gi*DW +: DW];
    acc = m_gv && in_srdy[m_gi] && (!m_of || o_drdy);
    rel = 1'b0;
    if (m_gv) begin
      case (grant_mode)
        2'd1:    rel = !in_srdy[m_gi];
        2'd2:    rel = acc && bool_end(w);
        default: rel = acc;
      endcase
    end
    if (acc) begin m_of = 1; m_od = w; end
    else if (o_drdy) m_of = 0;
    if (!m_gv) begin
      p = rr_choose(in_srdy, m_ptr);
      if (p >= 0) begin m_gv = 1; m_gi = p; end
    end else if (rel) begin
      m_gv = 0;
      m_ptr = (m_gi + 1) % N;
    end
  endtask

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst = 1'b1; grant_mode = md; in_srdy = '0; o_drdy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 o_srdy in reset", 32'(o_srdy), 32'd0);
    check("R1 in_drdy in reset", 32'(in_drdy), 32'd0);
    rst = 1'b0;
    m_gv = 0; m_of = 0; m_gi = 0; m_ptr = 0; m_od = '0;
  endtask

  task automatic run_phase(input int cycles);
    string tag;
    case (grant_mode)
      2'd1:    tag = "R2 R4 R6 R7 in_drdy";
      2'd2:    tag = "R2 R5 R6 R7 R9 in_drdy";
      default: tag = "R2 R3 R6 R7 in_drdy";
    endcase
    for (int c = 0; c < cycles; c++) begin
      // registered outputs, due one edge after the accepting cycle
      check("R8 o_srdy", 32'(o_srdy), 32'(m_of));
      if (m_of) check("R8 o_data", 32'(o_data), 32'(m_od));
      // drive
      for (int i = 0; i < N; i++) begin
        in_srdy[i] = ($urandom_range(99) < 60);
        in_data[i*DW +: DW] = DW'($urandom);
      end
      o_drdy = ($urandom_range(99) < 70);
      if (c >= 200 && c < 240) o_drdy = 1'b0;      // long downstream stall
      if (c >= 400 && c < 420) in_srdy = '0;       // idle stretch keeps pointer
      if (c >= 600 && c < 700) in_srdy = 4'b1000;  // lone requester at top index
      #1;
      check(tag, 32'(in_drdy), 32'(exp_drdy(o_drdy)));
      model_step();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int md = 0; md < 4; md++) begin
      do_reset(2'(md));
      run_phase(2500);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule